// File: doc/BRIEF.md
# Dual-Plane Flash Command Controller

This block sits between a parallel NOR-style flash bus and a flash array split into two planes. It watches strobes for chip enable, output enable and write enable, and turns the write cycles it sees into commands. From those commands it starts word programs and sector erases. Each plane has its own busy machine, so a read addressed to one plane returns array data while the other plane is still working.

Program and erase times are counted in clock cycles. A sector erase can be suspended for as long as needed. While it is held, the same plane may read or program any sector except the one being erased. A six-cycle unlock enters a mode in which every write pulse programs the addressed word directly. Only a long enough low pulse on the device reset pin, or a power-on reset, leaves that mode.

The array behind the controller is a small stand-in holding four words per sector, selected by the two lowest address bits. Word addresses are 20 bits. Bits [19:15] equal to zero select one of eight small sectors (0–7) through bits [14:12]. Any other value of bits [19:15] selects sector 7 + addr[19:15]. Sectors 0–14 form plane A and sectors 15–38 form plane B. Every bus access is a single strobe, and nothing at the edge exerts back-pressure. The read result arrives with a one-cycle `rd_vld` pulse that the bus master takes as it comes.

Top module: `flash_dual_plane_ctrl`

## Requirements
- R1: After power-on reset the controller is in read mode with `ready` high. A read returns 16'hFFFF from an untouched word, and a write that is not part of a command sequence leaves the array unchanged.
- R2: A program needs four write cycles, compared on addr[11:0] and wdata[7:0]: 555/AA, 2AA/55, 555/A0, then the target address and data. The stored word becomes old data AND new data. The plane stays busy for PROG_CYC cycles.
- R3: A command cycle whose address or data does not match the expected value returns the decoder to read mode, and the following writes program nothing.
- R4: A sector erase needs six write cycles: 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55, then any address in the sector with data 30. After ERASE_CYC cycles every word of that sector reads FFFF, and words in neighbouring sectors are unchanged.
- R5: While one plane is busy, a read addressed to the other plane returns array data.
- R6: A read addressed to a busy plane returns a status word. Bit 6 inverts on every such read, starting from 1 after reset. During a program, bit 7 is the inverse of bit 7 of the data being programmed; during an erase, bit 7 is 0. All other bits are 0.
- R7: `ready` is low while any plane is programming or running an erase, and high while the only pending operation is a suspended erase.
- R8: A single write with data B0 holds a running erase and freezes its remaining time. While the erase is held, a program to another sector of the same plane runs, and a program to the held sector is ignored. A single write with data 30 resumes the erase for the time that was left.
- R9: Five erase-setup cycles (555/AA, 2AA/55, 555/80, 555/AA, 2AA/55) followed by 555/60 enter single-pulse mode. In that mode each write programs its address with its data, and the codes 30 and B0 are programmed as data.
- R10: Single-pulse mode ends only when `dev_rst_n` is held low for RST_MIN_CYC clock cycles, or on power-on reset. A shorter low pulse leaves the mode active.
- R11: A program or erase aimed at a sector whose bit is set in LOCK_MASK is ignored. `ready` stays high and the data stays unchanged.
- R12: `dev_rst_n` low aborts any program, erase and partly entered command sequence. `ready` is high on the next cycle, and an aborted program leaves its word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears everything |
| dev_rst_n | input | 1 | Device reset pin, active low, aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 20 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data or status word |
| rd_vld | output | 1 | One-cycle pulse marking a new `rdata` |
| ready | output | 1 | High when no plane operation is running |

## Verification
Corruption in a per-plane busy machine shows at `ready` on the cycle after the write that starts an operation. It also shows as a status word appearing on, or missing from, a read of the wrong plane one cycle later. A decoder stuck in an unlock state is exposed at the next program: the word either stays FFFF or changes when it should not, and that is visible a program time later. A lost or stuck single-pulse flag, or a frozen erase that keeps counting, only appears after a full operation time, when a read returns data that was either programmed or erased against the rules.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int ADDR_W      = 20;
  localparam int DATA_W      = 16;
  localparam int N_SECT      = 39;
  localparam int SECT_W      = 6;
  localparam int SLOT_W      = 2;
  localparam int N_PLANE     = 2;
  localparam int SMALL_N     = 8;
  localparam int SMALL_SHIFT = 12;
  localparam int BIG_SHIFT   = 15;
  localparam int B_FIRST     = 15;

  localparam logic [11:0] A_UNL1 = 12'h555;
  localparam logic [11:0] A_UNL2 = 12'h2AA;
  localparam logic [7:0]  K_UNL1 = 8'hAA;
  localparam logic [7:0]  K_UNL2 = 8'h55;
  localparam logic [7:0]  K_PROG = 8'hA0;
  localparam logic [7:0]  K_ESET = 8'h80;
  localparam logic [7:0]  K_SERA = 8'h30;
  localparam logic [7:0]  K_SUSP = 8'hB0;
  localparam logic [7:0]  K_RESM = 8'h30;
  localparam logic [7:0]  K_SPM  = 8'h60;

  typedef logic [SECT_W-1:0] sect_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PDATA, SQ_E0, SQ_E1, SQ_E2
  } seq_st_t;

  // small boot sectors first, then large sectors numbered on from there
  function automatic sect_t sect_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:BIG_SHIFT] == '0)
      return sect_t'(a[BIG_SHIFT-1:SMALL_SHIFT]);
    return sect_t'(a[ADDR_W-1:BIG_SHIFT]) + sect_t'(SMALL_N - 1);
  endfunction

  function automatic logic plane_of(input sect_t s);
    return s >= sect_t'(B_FIRST);
  endfunction
endpackage

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode
  import fcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        wr_evt,
  input  logic        sp_mode,
  input  logic [11:0] cmd_addr,
  input  logic [7:0]  cmd_data,
  output logic        do_prog,
  output logic        do_erase,
  output logic        do_susp,
  output logic        do_resume,
  output logic        do_spm
);
  seq_st_t st, st_nxt;
  logic a1, a2;

  assign a1 = (cmd_addr == A_UNL1);
  assign a2 = (cmd_addr == A_UNL2);

  always_comb begin
    st_nxt    = st;
    do_prog   = 1'b0;
    do_erase  = 1'b0;
    do_susp   = 1'b0;
    do_resume = 1'b0;
    do_spm    = 1'b0;
    if (wr_evt) begin
      if (sp_mode) begin
        do_prog = 1'b1;
        st_nxt  = SQ_IDLE;
      end else begin
        st_nxt = SQ_IDLE;
        unique case (st)
          SQ_IDLE: begin
            if (a1 && cmd_data == K_UNL1) st_nxt = SQ_U1;
            else if (cmd_data == K_SUSP)  do_susp = 1'b1;
            else if (cmd_data == K_RESM)  do_resume = 1'b1;
          end
          SQ_U1:   if (a2 && cmd_data == K_UNL2) st_nxt = SQ_U2;
          SQ_U2: begin
            if (a1 && cmd_data == K_PROG)      st_nxt = SQ_PDATA;
            else if (a1 && cmd_data == K_ESET) st_nxt = SQ_E0;
          end
          SQ_PDATA: do_prog = 1'b1;
          SQ_E0:   if (a1 && cmd_data == K_UNL1) st_nxt = SQ_E1;
          SQ_E1:   if (a2 && cmd_data == K_UNL2) st_nxt = SQ_E2;
          SQ_E2: begin
            if (cmd_data == K_SERA)            do_erase = 1'b1;
            else if (a1 && cmd_data == K_SPM)  do_spm = 1'b1;
          end
          default: st_nxt = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= SQ_IDLE;
    else if (flush) st <= SQ_IDLE;
    else            st <= st_nxt;
  end
endmodule

// File: rtl/fcc_plane.sv
module fcc_plane
  import fcc_pkg::*;
#(
  parameter int PROG_CYC  = 5000,
  parameter int ERASE_CYC = 75000000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              susp,
  input  logic              resume,
  input  sect_t             req_sect,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [DATA_W-1:0] req_data,
  output logic              running,
  output logic              prog_busy,
  output logic              erase_held,
  output logic              poll_bit,
  output logic              cm_vld,
  output logic              cm_erase,
  output sect_t             cm_sect,
  output logic [SLOT_W-1:0] cm_slot,
  output logic [DATA_W-1:0] cm_data
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic              prog_on, er_on, er_held;
  logic [CNT_W-1:0]  p_cnt, e_cnt;
  sect_t             p_sect, e_sect;
  logic [SLOT_W-1:0] p_slot;
  logic [DATA_W-1:0] p_data;
  logic              p_done, e_done, acc_p, acc_e;

  assign p_done = prog_on && (p_cnt == '0);
  assign e_done = er_on && !er_held && (e_cnt == '0);
  // program allowed when idle, or into another sector of a held erase
  assign acc_p  = start_prog && !prog_on && (!er_on || (er_held && req_sect != e_sect));
  assign acc_e  = start_erase && !prog_on && !er_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_on <= 1'b0; er_on <= 1'b0; er_held <= 1'b0;
      p_cnt <= '0; e_cnt <= '0; p_sect <= '0; e_sect <= '0;
      p_slot <= '0; p_data <= '0;
    end else if (flush) begin
      prog_on <= 1'b0; er_on <= 1'b0; er_held <= 1'b0;
    end else begin
      if (acc_p) begin
        prog_on <= 1'b1;
        p_cnt   <= CNT_W'(PROG_CYC - 1);
        p_sect  <= req_sect;
        p_slot  <= req_slot;
        p_data  <= req_data;
      end else if (prog_on) begin
        if (p_cnt == '0) prog_on <= 1'b0;
        else             p_cnt   <= p_cnt - 1'b1;
      end

      if (acc_e) begin
        er_on   <= 1'b1;
        er_held <= 1'b0;
        e_cnt   <= CNT_W'(ERASE_CYC - 1);
        e_sect  <= req_sect;
      end else if (er_on) begin
        if (er_held) begin
          if (resume && !prog_on) er_held <= 1'b0;
        end else if (e_cnt == '0) begin
          er_on <= 1'b0;
        end else begin
          e_cnt <= e_cnt - 1'b1;
          if (susp) er_held <= 1'b1;
        end
      end
    end
  end

  assign running    = prog_on | (er_on & ~er_held);
  assign prog_busy  = prog_on;
  assign erase_held = er_on & er_held;
  assign poll_bit   = prog_on ? ~p_data[7] : 1'b0;
  assign cm_vld     = p_done | e_done;
  assign cm_erase   = e_done;
  assign cm_sect    = e_done ? e_sect : p_sect;
  assign cm_slot    = p_slot;
  assign cm_data    = p_data;
endmodule

// File: rtl/fcc_store.sv
module fcc_store
  import fcc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  sect_t                          rd_sect,
  input  logic [SLOT_W-1:0]              rd_slot,
  output logic [DATA_W-1:0]              rd_word,
  input  logic [N_PLANE-1:0]             cm_vld,
  input  logic [N_PLANE-1:0]             cm_erase,
  input  logic [N_PLANE-1:0][SECT_W-1:0] cm_sect,
  input  logic [N_PLANE-1:0][SLOT_W-1:0] cm_slot,
  input  logic [N_PLANE-1:0][DATA_W-1:0] cm_data
);
  localparam int DEPTH = N_SECT << SLOT_W;
  localparam int SLOTS = 1 << SLOT_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_word = mem[{rd_sect, rd_slot}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int p = 0; p < N_PLANE; p++) begin
        if (cm_vld[p]) begin
          if (cm_erase[p]) begin
            for (int s = 0; s < SLOTS; s++)
              mem[{cm_sect[p], SLOT_W'(s)}] <= '1;
          end else begin
            // programming only clears bits
            mem[{cm_sect[p], cm_slot[p]}] <= mem[{cm_sect[p], cm_slot[p]}] & cm_data[p];
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_dual_plane_ctrl.sv
module flash_dual_plane_ctrl
  import fcc_pkg::*;
#(
  parameter int              PROG_CYC    = 5000,
  parameter int              ERASE_CYC   = 75000000,
  parameter int              RST_MIN_CYC = 125,
  parameter logic [38:0]     LOCK_MASK   = '0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dev_rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [19:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rd_vld,
  output logic        ready
);
  localparam int          RC_W   = $clog2(RST_MIN_CYC + 1);
  localparam logic [63:0] LOCK_W = 64'(LOCK_MASK);

  logic wr_act, rd_act, wr_q, rd_q, wr_evt, rd_evt, flush;
  logic do_prog, do_erase, do_susp, do_resume, do_spm;
  logic sp_mode;
  logic [RC_W-1:0] rst_cnt;
  sect_t sect;
  logic  pl, lock_hit;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] rd_word, status;
  logic [N_PLANE-1:0] running, prog_busy, erase_held, poll, tog;
  logic [N_PLANE-1:0] cm_vld, cm_erase;
  logic [N_PLANE-1:0][SECT_W-1:0] cm_sect;
  logic [N_PLANE-1:0][SLOT_W-1:0] cm_slot;
  logic [N_PLANE-1:0][DATA_W-1:0] cm_data;

  assign flush    = ~dev_rst_n;
  assign wr_act   = ~ce_n & ~we_n;
  assign rd_act   = ~ce_n & ~oe_n & we_n;
  assign wr_evt   = wr_act & ~wr_q & dev_rst_n;
  assign rd_evt   = rd_act & ~rd_q & dev_rst_n;
  assign sect     = sect_of(addr);
  assign pl       = plane_of(sect);
  assign slot     = addr[SLOT_W-1:0];
  assign lock_hit = LOCK_W[sect];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  fcc_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_evt(wr_evt),
    .sp_mode(sp_mode), .cmd_addr(addr[11:0]), .cmd_data(wdata[7:0]),
    .do_prog(do_prog), .do_erase(do_erase), .do_susp(do_susp),
    .do_resume(do_resume), .do_spm(do_spm)
  );

  // single-pulse mode: set by command, cleared only by a long device reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_mode <= 1'b0;
      rst_cnt <= '0;
    end else if (!dev_rst_n) begin
      if (rst_cnt == RC_W'(RST_MIN_CYC - 1)) sp_mode <= 1'b0;
      else                                   rst_cnt <= rst_cnt + 1'b1;
    end else begin
      rst_cnt <= '0;
      if (do_spm) sp_mode <= 1'b1;
    end
  end

  for (genvar p = 0; p < N_PLANE; p++) begin : g_plane
    logic sel;
    assign sel = (pl == 1'(p));
    fcc_plane #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_plane (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .start_prog(do_prog & ~lock_hit & sel),
      .start_erase(do_erase & ~lock_hit & sel),
      .susp(do_susp), .resume(do_resume),
      .req_sect(sect), .req_slot(slot), .req_data(wdata),
      .running(running[p]), .prog_busy(prog_busy[p]),
      .erase_held(erase_held[p]), .poll_bit(poll[p]),
      .cm_vld(cm_vld[p]), .cm_erase(cm_erase[p]), .cm_sect(cm_sect[p]),
      .cm_slot(cm_slot[p]), .cm_data(cm_data[p])
    );
  end

  fcc_store u_store (
    .clk(clk), .rst_n(rst_n), .rd_sect(sect), .rd_slot(slot),
    .rd_word(rd_word), .cm_vld(cm_vld), .cm_erase(cm_erase),
    .cm_sect(cm_sect), .cm_slot(cm_slot), .cm_data(cm_data)
  );

  always_comb begin
    status    = '0;
    status[7] = poll[pl];
    status[6] = ~tog[pl];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_vld <= 1'b0;
      tog    <= '0;
    end else begin
      rd_vld <= rd_evt;
      if (rd_evt) begin
        if (running[pl]) begin
          tog[pl] <= ~tog[pl];
          rdata   <= status;
        end else begin
          rdata <= rd_word;
        end
      end
    end
  end

  assign ready = ~|running;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter logic [38:0] LOCK_MASK = '0
)(
  input logic            clk,
  input logic            rst_n,
  input logic            dev_rst_n,
  input logic            ce_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            ready,
  input logic            rd_vld,
  input logic            sp_mode,
  input logic [1:0]      prog_busy,
  input logic [1:0]      cm_vld,
  input logic [1:0][5:0] cm_sect
);
  localparam logic [63:0] LK = 64'(LOCK_MASK);

  // R12: device reset releases every plane by the next cycle
  p_devrst_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |=> ready);

  // R1: read data is only flagged after a read strobe
  p_rdvld_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(!ce_n && !oe_n && we_n && dev_rst_n));

  // R10: single-pulse mode is never left while the reset pin is high
  p_spm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_mode && dev_rst_n) |=> sp_mode);

  // R11: no commit ever lands in a locked sector
  p_lock_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld[0] |-> !LK[cm_sect[0]]);
  p_lock_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld[1] |-> !LK[cm_sect[1]]);

  // R7: a program starting in either plane drops ready
  p_busy_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy[0]) |-> !ready);
  p_busy_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy[1]) |-> !ready);
endmodule

bind flash_dual_plane_ctrl fcc_checker #(.LOCK_MASK(LOCK_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .ce_n(ce_n),
  .oe_n(oe_n), .we_n(we_n), .ready(ready), .rd_vld(rd_vld),
  .sp_mode(sp_mode), .prog_busy(prog_busy), .cm_vld(cm_vld),
  .cm_sect(cm_sect)
);

// File: tb/flash_dual_plane_ctrl_tb.sv
`timescale 1ns/1ps
module flash_dual_plane_ctrl_tb;
  localparam int          PROG_CYC    = 6;
  localparam int          ERASE_CYC   = 40;
  localparam int          RST_MIN_CYC = 8;
  localparam logic [38:0] LOCK_MASK   = (39'd1 << 3) | (39'd1 << 20);

  logic clk = 1'b0;
  logic rst_n = 1'b0, dev_rst_n = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rd_vld, ready;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  flash_dual_plane_ctrl #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .RST_MIN_CYC(RST_MIN_CYC), .LOCK_MASK(LOCK_MASK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_vld(rd_vld), .ready(ready)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read and compare, 2 wait, 3 compare ready
    logic [19:0] addr;
    logic [15:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    // R1: reset state and stray write
    '{2'd1, 20'h00010, 16'hFFFF, 4'd1},
    '{2'd0, 20'h00010, 16'h1234, 4'd1},
    '{2'd1, 20'h00010, 16'hFFFF, 4'd1},
    '{2'd3, 20'h00000, 16'h0001, 4'd1},
    // R2: program, busy window (R7), then AND with old data
    '{2'd0, 20'h00555, 16'h00AA, 4'd2},
    '{2'd0, 20'h002AA, 16'h0055, 4'd2},
    '{2'd0, 20'h00555, 16'h00A0, 4'd2},
    '{2'd0, 20'h00010, 16'hF0F3, 4'd2},
    '{2'd3, 20'h00000, 16'h0000, 4'd7},
    '{2'd2, 20'h00000, 16'd8,    4'd2},
    '{2'd3, 20'h00000, 16'h0001, 4'd7},
    '{2'd1, 20'h00010, 16'hF0F3, 4'd2},
    '{2'd0, 20'h00555, 16'h00AA, 4'd2},
    '{2'd0, 20'h002AA, 16'h0055, 4'd2},
    '{2'd0, 20'h00555, 16'h00A0, 4'd2},
    '{2'd0, 20'h00010, 16'h0FFF, 4'd2},
    '{2'd2, 20'h00000, 16'd8,    4'd2},
    '{2'd1, 20'h00010, 16'h00F3, 4'd2},
    // R3: broken unlock cycle
    '{2'd0, 20'h00555, 16'h00AA, 4'd3},
    '{2'd0, 20'h002AA, 16'h0054, 4'd3},
    '{2'd0, 20'h00555, 16'h00A0, 4'd3},
    '{2'd0, 20'h00010, 16'h0000, 4'd3},
    '{2'd3, 20'h00000, 16'h0001, 4'd3},
    '{2'd1, 20'h00010, 16'h00F3, 4'd3},
    // R5: plane B busy, plane A readable
    '{2'd0, 20'h00555, 16'h00AA, 4'd5},
    '{2'd0, 20'h002AA, 16'h0055, 4'd5},
    '{2'd0, 20'h00555, 16'h00A0, 4'd5},
    '{2'd0, 20'h40000, 16'h1111, 4'd5},
    '{2'd1, 20'h00010, 16'h00F3, 4'd5},
    '{2'd3, 20'h00000, 16'h0000, 4'd7},
    '{2'd2, 20'h00000, 16'd8,    4'd5},
    '{2'd1, 20'h40000, 16'h1111, 4'd5},
    // R6: status reads with polling bit and toggle
    '{2'd0, 20'h00555, 16'h00AA, 4'd6},
    '{2'd0, 20'h002AA, 16'h0055, 4'd6},
    '{2'd0, 20'h00555, 16'h00A0, 4'd6},
    '{2'd0, 20'h40001, 16'h0080, 4'd6},
    '{2'd1, 20'h40002, 16'h0040, 4'd6},
    '{2'd1, 20'h40002, 16'h0000, 4'd6},
    '{2'd2, 20'h00000, 16'd8,    4'd6},
    '{2'd1, 20'h40001, 16'h0080, 4'd6}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [19:0] a, output logic [15:0] got);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    got = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [19:0] a, input logic [15:0] exp);
    logic [15:0] got;
    bus_rd(a, got);
    chk(tag, got, exp);
  endtask

  task automatic unlock3(input logic [7:0] code);
    bus_wr(20'h00555, 16'h00AA);
    bus_wr(20'h002AA, 16'h0055);
    bus_wr(20'h00555, {8'h00, code});
  endtask

  task automatic erase_setup();
    unlock3(8'h80);
    bus_wr(20'h00555, 16'h00AA);
    bus_wr(20'h002AA, 16'h0055);
  endtask

  task automatic pulse_dev_rst(input int n);
    @(negedge clk);
    dev_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    dev_rst_n = 1'b1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {15'd0, ready}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [15:0] got;
      tag = $sformatf("R%0d table step %0d", VECS[i].req, i);
      case (VECS[i].op)
        2'd0: bus_wr(VECS[i].addr, VECS[i].data);
        2'd1: begin bus_rd(VECS[i].addr, got); chk(tag, got, VECS[i].data); end
        2'd2: repeat (int'(VECS[i].data)) @(negedge clk);
        default: chk(tag, {15'd0, ready}, VECS[i].data);
      endcase
    end

    // R4 / R8: erase of sector 8 with suspend, program around it, resume
    unlock3(8'hA0); bus_wr(20'h08000, 16'h1234);
    repeat (8) @(negedge clk);
    unlock3(8'hA0); bus_wr(20'h07FFF, 16'h5555);
    repeat (8) @(negedge clk);
    erase_setup(); bus_wr(20'h0FFFE, 16'h0030);
    chk("R7 ready low during erase", {15'd0, ready}, 16'h0000);
    rd_chk("R6 erase status first read", 20'h00000, 16'h0040);
    rd_chk("R6 erase status second read", 20'h00000, 16'h0000);
    bus_wr(20'h00000, 16'h00B0);
    chk("R7 ready high while suspended", {15'd0, ready}, 16'h0001);
    unlock3(8'hA0); bus_wr(20'h10000, 16'h00FF);
    chk("R8 program other sector during suspend busy", {15'd0, ready}, 16'h0000);
    repeat (8) @(negedge clk);
    unlock3(8'hA0); bus_wr(20'h08001, 16'h0000);
    chk("R8 program to held sector ignored", {15'd0, ready}, 16'h0001);
    repeat (50) @(negedge clk);
    rd_chk("R8 erase frozen while held", 20'h08000, 16'h1234);
    rd_chk("R8 program beside held sector", 20'h10000, 16'h00FF);
    bus_wr(20'h00000, 16'h0030);
    chk("R8 resume makes plane busy", {15'd0, ready}, 16'h0000);
    repeat (ERASE_CYC + 4) @(negedge clk);
    chk("R4 erase finishes", {15'd0, ready}, 16'h0001);
    rd_chk("R4 erased word", 20'h08000, 16'hFFFF);
    rd_chk("R4 erased second word", 20'h08001, 16'hFFFF);
    rd_chk("R4 small sector below boundary kept", 20'h07FFF, 16'h5555);
    rd_chk("R4 next sector kept", 20'h10000, 16'h00FF);

    // R11: locked sectors 3 and 20
    unlock3(8'hA0); bus_wr(20'h03000, 16'h0000);
    chk("R11 locked program keeps ready", {15'd0, ready}, 16'h0001);
    repeat (8) @(negedge clk);
    rd_chk("R11 locked word unchanged", 20'h03000, 16'hFFFF);
    erase_setup(); bus_wr(20'h68000, 16'h0030);
    chk("R11 locked erase keeps ready", {15'd0, ready}, 16'h0001);

    // R12: abort a program and a partial sequence
    unlock3(8'hA0); bus_wr(20'h01000, 16'h0000);
    repeat (2) @(negedge clk);
    pulse_dev_rst(2);
    chk("R12 ready after device reset", {15'd0, ready}, 16'h0001);
    repeat (8) @(negedge clk);
    rd_chk("R12 aborted program leaves data", 20'h01000, 16'hFFFF);
    bus_wr(20'h00555, 16'h00AA);
    bus_wr(20'h002AA, 16'h0055);
    pulse_dev_rst(1);
    bus_wr(20'h00555, 16'h00A0);
    bus_wr(20'h01000, 16'h0000);
    repeat (8) @(negedge clk);
    rd_chk("R12 sequence flushed by reset", 20'h01000, 16'hFFFF);

    // R9: single-pulse mode entry and raw writes
    erase_setup(); bus_wr(20'h00555, 16'h0060);
    bus_wr(20'h01001, 16'h0F0F);
    chk("R9 single pulse write starts program", {15'd0, ready}, 16'h0000);
    repeat (8) @(negedge clk);
    rd_chk("R9 single pulse data", 20'h01001, 16'h0F0F);
    bus_wr(20'h01002, 16'h0030);
    repeat (8) @(negedge clk);
    rd_chk("R9 erase code stored as data", 20'h01002, 16'h0030);
    bus_wr(20'h01003, 16'h00B0);
    repeat (8) @(negedge clk);
    rd_chk("R9 suspend code stored as data", 20'h01003, 16'h00B0);

    // R10: short reset keeps the mode, long reset ends it
    pulse_dev_rst(3);
    bus_wr(20'h02000, 16'h1111);
    repeat (8) @(negedge clk);
    rd_chk("R10 short reset keeps single pulse", 20'h02000, 16'h1111);
    pulse_dev_rst(RST_MIN_CYC + 4);
    bus_wr(20'h02001, 16'h2222);
    chk("R10 long reset ends single pulse", {15'd0, ready}, 16'h0001);
    repeat (8) @(negedge clk);
    rd_chk("R10 raw write ignored after exit", 20'h02001, 16'hFFFF);

    done = 1'b1;
    report();
    $finish;
  end
endmodule